// File: doc/BRIEF.md
# Quad DAC Load-Update Controller

This block sits between a byte-wide register write bus and four DAC channels (A, B, C, D). Each channel has a per-channel holding byte for its low half, a staging register that receives a full code, and an active register that drives the converter. The block's main job is deciding when staged codes move into the active registers. Only digital codes and select bits leave the block.

Each channel code is written as a low byte followed by a high byte. The low byte waits in the holding byte. It is committed to the staging register in the same cycle as the high byte, so a staged code is never half updated. Transfers to the active registers have one of three sources, chosen through three 8-bit control registers:

- an active-low external load pin, synchronized with a flop chain and acting on its falling edge;
- automatic triggers on high-byte writes, in one of several grouping modes;
- self-clearing software trigger bits.

The same control registers also carry the range, reference, buffer-bypass, conversion-speed, thermal-resolution and temperature-routing selects to output pins.

Top module: `qdac_load_ctrl`

## Requirements
- R1: After reset, all three control registers read 0x00, every staged and active code is zero, and every select output is 0.
- R2: Control register 3 sits at 0x1A. Bit 0 drives `fast_conv`, bit 1 drives `therm_10bit`, bit 3 is the update-source select, bit 5 drives `route_int_a` and bit 6 drives `route_ext_b`. Bits 2, 4 and 7 are reserved: they are stored as 0 and read back 0 whatever is written.
- R3: Channel bytes use addresses 0x10 to 0x17. Channel n's low byte is at 0x10+2n and its high byte at 0x11+2n, with n = 0..3 for A..D. A low-byte write changes no staged code. A high-byte write stages {high[CODE_W-9:0], held low byte} in one step. Reading a channel address returns the staged byte, with the high byte zero-extended.
- R4: While control register 3 bit 3 is 0, high-byte writes and software trigger bits never change an active code. A falling edge on `load_n` loads all four active registers from staging. The load happens on the third rising clock edge after the pin is first sampled low.
- R5: While control register 3 bit 3 is 1, `load_n` has no effect on the active codes.
- R6: The DAC configuration register is at 0x1B and bits [5:4] select the grouping mode. With 00, a high-byte write to a channel updates only that channel.
- R7: Grouping mode 01: a high-byte write to B updates A and B, a high-byte write to D updates C and D, and high-byte writes to A or C update nothing.
- R8: Grouping mode 10: only a high-byte write to D causes an update, and it loads all four channels.
- R9: Grouping mode 11: high-byte writes update nothing. Writing the load register at 0x1C with bit n = 1 updates channel n alone, for n = 0..3 (A..D).
- R10: Load register bits [3:0] self-clear and always read 0. Bit 4 drives `ref_internal` (1 = internal reference). Bits [7:5] are stored as 0 and read 0.
- R11: DAC configuration bits [3:0] drive `range_2x` for A..D (1 = double range). Bit 6 drives `bypass_ab` and bit 7 drives `bypass_cd`. All of these read back as written.
- R12: An update caused by a bus write reaches the active code on the rising edge after the write's edge, and it carries the high byte written in that same write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per byte |
| wr_addr | input | 8 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 8 | Read address |
| rd_data | output | 8 | Combinational read data |
| load_n | input | 1 | Asynchronous active-low external load pin |
| dac_code | output | 4*CODE_W | Active codes, channel A in the lowest slice |
| range_2x | output | 4 | Per-channel double-range select |
| bypass_ab | output | 1 | Reference buffer bypass, channels A/B |
| bypass_cd | output | 1 | Reference buffer bypass, channels C/D |
| ref_internal | output | 1 | Internal reference select |
| fast_conv | output | 1 | Fast conversion clock select |
| therm_10bit | output | 1 | 10-bit thermal output resolution |
| route_int_a | output | 1 | Internal temperature routed to channel A |
| route_ext_b | output | 1 | External temperature routed to channel B |

## Verification
The assertions check on every cycle that:
- reserved and self-clearing bits hold zero;
- the update request vector keeps the shape of its grouping mode: one-hot in mode 00, paired in mode 01, all-or-nothing in mode 10;
- no bus-write request arises in pin mode;
- the pin-edge pulse lasts a single cycle;
- a staged code moves only on a high-byte write.

Only the bench scenarios can show the data path: which code values end up in which active registers, on exactly which edge, and that the pin is truly ignored in software mode.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
   localparam int NUM_CH = 4;

   typedef enum logic [1:0] {
      GRP_SINGLE   = 2'b00,
      GRP_PAIR     = 2'b01,
      GRP_ALL_ON_D = 2'b10,
      GRP_SOFT     = 2'b11
   } grp_mode_e;

   // Bits of control register 3 that are stored; the others are reserved
   localparam logic [7:0] CTRL_KEEP_MASK = 8'h6B;
   localparam int CTRL_SRC_BIT = 3;
endpackage

// File: rtl/qdac_cfg_regs.sv
module qdac_cfg_regs
   import qdac_pkg::*;
#(
   parameter logic [7:0] CTRL_ADDR = 8'h1A,
   parameter logic [7:0] DCFG_ADDR = 8'h1B,
   parameter logic [7:0] LOAD_ADDR = 8'h1C
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [7:0] wr_addr,
   input  logic [7:0] wr_data,
   input  logic [7:0] rd_addr,
   output logic [7:0] ctrl_q,
   output logic [7:0] dcfg_q,
   output logic       ref_int_q,
   output logic       soft_we,
   output logic [3:0] soft_bits,
   output logic       cfg_hit,
   output logic [7:0] cfg_rd_data
);
   generate
      if (CTRL_ADDR == DCFG_ADDR || CTRL_ADDR == LOAD_ADDR || DCFG_ADDR == LOAD_ADDR) begin : g_bad_map
         $error("qdac_cfg_regs: control register addresses must be distinct");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q    <= '0;
         dcfg_q    <= '0;
         ref_int_q <= 1'b0;
      end else if (wr_en) begin
         if (wr_addr == CTRL_ADDR) ctrl_q    <= wr_data & CTRL_KEEP_MASK;
         if (wr_addr == DCFG_ADDR) dcfg_q    <= wr_data;
         if (wr_addr == LOAD_ADDR) ref_int_q <= wr_data[4];
      end
   end

   assign soft_we   = wr_en && (wr_addr == LOAD_ADDR);
   assign soft_bits = wr_data[3:0];

   always_comb begin
      cfg_hit     = 1'b1;
      cfg_rd_data = '0;
      if (rd_addr == CTRL_ADDR)      cfg_rd_data = ctrl_q;
      else if (rd_addr == DCFG_ADDR) cfg_rd_data = dcfg_q;
      else if (rd_addr == LOAD_ADDR) cfg_rd_data = {3'b000, ref_int_q, 4'b0000};
      else                           cfg_hit     = 1'b0;
   end

   AST_CTRL_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q & ~CTRL_KEEP_MASK) == 8'h00); // R2
   AST_LOAD_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr == LOAD_ADDR) |-> (cfg_rd_data[3:0] == 4'h0 && cfg_rd_data[7:5] == 3'b000)); // R10
endmodule

// File: rtl/qdac_pin_sync.sv
module qdac_pin_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_n,
   output logic fall
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("qdac_pin_sync: at least two synchronizer stages are required");
      end
   endgenerate

   // Chain element 0 is the first synchronizer flop; the last is the edge history flop
   logic [SYNC_STAGES:0] chain_q;

   genvar gi;
   generate
      for (gi = 0; gi <= SYNC_STAGES; gi++) begin : g_stage
         if (gi == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[gi] <= 1'b1;
               else        chain_q[gi] <= pin_n;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[gi] <= 1'b1;
               else        chain_q[gi] <= chain_q[gi-1];
            end
         end
      end
   endgenerate

   assign fall = chain_q[SYNC_STAGES] & ~chain_q[SYNC_STAGES-1];

   AST_PIN_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      fall |=> !fall); // R4
endmodule

// File: rtl/qdac_trig_decode.sv
module qdac_trig_decode
   import qdac_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sw_mode,
   input  grp_mode_e         grp_mode,
   input  logic [NUM_CH-1:0] msb_we,
   input  logic              soft_we,
   input  logic [3:0]        soft_bits,
   output logic [NUM_CH-1:0] req
);
   always_comb begin
      req = '0;
      if (sw_mode) begin
         unique case (grp_mode)
            GRP_SINGLE:   req = msb_we;
            GRP_PAIR:     req = {msb_we[3], msb_we[3], msb_we[1], msb_we[1]};
            GRP_ALL_ON_D: req = {NUM_CH{msb_we[3]}};
            GRP_SOFT:     req = soft_we ? soft_bits : '0;
            default:      req = '0;
         endcase
      end
   end

   AST_PIN_MODE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      !sw_mode |-> (req == '0)); // R4
   AST_SINGLE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_mode && grp_mode == GRP_SINGLE) |-> $onehot0(req)); // R6
   AST_PAIR_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_mode && grp_mode == GRP_PAIR) |-> (req[0] == req[1] && req[2] == req[3])); // R7
   AST_ALL_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_mode && grp_mode == GRP_ALL_ON_D) |-> (req == '0 || req == '1)); // R8
   AST_SOFT_NO_MSB: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_mode && grp_mode == GRP_SOFT && !soft_we) |-> (req == '0)); // R9
endmodule

// File: rtl/qdac_channel.sv
module qdac_channel #(
   parameter int CODE_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lsb_we,
   input  logic              msb_we,
   input  logic [7:0]        wdata,
   input  logic              load,
   output logic [CODE_W-1:0] staged,
   output logic [CODE_W-1:0] active
);
   localparam int HI_W = CODE_W - 8;

   logic [7:0] hold_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= '0;
         staged <= '0;
         active <= '0;
      end else begin
         if (lsb_we) hold_q <= wdata;
         if (msb_we) staged <= {wdata[HI_W-1:0], hold_q};
         if (load)   active <= staged;
      end
   end

   AST_STAGE_ONLY_ON_MSB: assert property (@(posedge clk) disable iff (!rst_n)
      !msb_we |=> $stable(staged)); // R3
endmodule

// File: rtl/qdac_load_ctrl.sv
module qdac_load_ctrl
   import qdac_pkg::*;
#(
   parameter int         CODE_W      = 12,
   parameter int         SYNC_STAGES = 2,
   parameter logic [7:0] CHAN_BASE   = 8'h10,
   parameter logic [7:0] CTRL_ADDR   = 8'h1A,
   parameter logic [7:0] DCFG_ADDR   = 8'h1B,
   parameter logic [7:0] LOAD_ADDR   = 8'h1C
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [7:0]               wr_addr,
   input  logic [7:0]               wr_data,
   input  logic [7:0]               rd_addr,
   output logic [7:0]               rd_data,
   input  logic                     load_n,
   output logic [NUM_CH*CODE_W-1:0] dac_code,
   output logic [NUM_CH-1:0]        range_2x,
   output logic                     bypass_ab,
   output logic                     bypass_cd,
   output logic                     ref_internal,
   output logic                     fast_conv,
   output logic                     therm_10bit,
   output logic                     route_int_a,
   output logic                     route_ext_b
);
   localparam int         CHAN_SPAN = 2 * NUM_CH;
   localparam logic [7:0] CHAN_LAST = CHAN_BASE + 8'(CHAN_SPAN - 1);

   generate
      if (CODE_W < 9 || CODE_W > 16) begin : g_bad_width
         $error("qdac_load_ctrl: CODE_W must lie in 9..16");
      end
      if (int'(CHAN_BASE) + CHAN_SPAN > 256) begin : g_bad_base
         $error("qdac_load_ctrl: channel window exceeds the address space");
      end
      if ((CTRL_ADDR >= CHAN_BASE && CTRL_ADDR <= CHAN_LAST) ||
          (DCFG_ADDR >= CHAN_BASE && DCFG_ADDR <= CHAN_LAST) ||
          (LOAD_ADDR >= CHAN_BASE && LOAD_ADDR <= CHAN_LAST)) begin : g_bad_overlap
         $error("qdac_load_ctrl: control registers overlap channel window");
      end
   endgenerate

   logic [7:0]  ctrl_q, dcfg_q;
   logic        soft_we, cfg_hit;
   logic [3:0]  soft_bits;
   logic [7:0]  cfg_rd_data;
   logic        sw_mode;
   grp_mode_e   grp_mode;

   qdac_cfg_regs #(
      .CTRL_ADDR (CTRL_ADDR),
      .DCFG_ADDR (DCFG_ADDR),
      .LOAD_ADDR (LOAD_ADDR)
   ) u_cfg (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (wr_en),
      .wr_addr     (wr_addr),
      .wr_data     (wr_data),
      .rd_addr     (rd_addr),
      .ctrl_q      (ctrl_q),
      .dcfg_q      (dcfg_q),
      .ref_int_q   (ref_internal),
      .soft_we     (soft_we),
      .soft_bits   (soft_bits),
      .cfg_hit     (cfg_hit),
      .cfg_rd_data (cfg_rd_data)
   );

   assign sw_mode     = ctrl_q[CTRL_SRC_BIT];
   assign grp_mode    = grp_mode_e'(dcfg_q[5:4]);
   assign fast_conv   = ctrl_q[0];
   assign therm_10bit = ctrl_q[1];
   assign route_int_a = ctrl_q[5];
   assign route_ext_b = ctrl_q[6];
   assign range_2x    = dcfg_q[3:0];
   assign bypass_ab   = dcfg_q[6];
   assign bypass_cd   = dcfg_q[7];

   // Channel window decode
   logic [7:0] wr_off, rd_off;
   logic       wr_chan_hit, rd_chan_hit;

   assign wr_off      = wr_addr - CHAN_BASE;
   assign rd_off      = rd_addr - CHAN_BASE;
   assign wr_chan_hit = wr_en && (wr_addr >= CHAN_BASE) && (wr_addr <= CHAN_LAST);
   assign rd_chan_hit = (rd_addr >= CHAN_BASE) && (rd_addr <= CHAN_LAST);

   logic [NUM_CH-1:0] lsb_we, msb_we, req, upd_q, load_vec;
   logic              pin_fall, pin_fire;
   logic [CODE_W-1:0] staged [NUM_CH];
   logic [CODE_W-1:0] active [NUM_CH];

   qdac_pin_sync #(.SYNC_STAGES(SYNC_STAGES)) u_pin (
      .clk   (clk),
      .rst_n (rst_n),
      .pin_n (load_n),
      .fall  (pin_fall)
   );

   assign pin_fire = pin_fall && !sw_mode;

   qdac_trig_decode u_trig (
      .clk       (clk),
      .rst_n     (rst_n),
      .sw_mode   (sw_mode),
      .grp_mode  (grp_mode),
      .msb_we    (msb_we),
      .soft_we   (soft_we),
      .soft_bits (soft_bits),
      .req       (req)
   );

   // Requests wait one edge so the staging register already holds the new high byte
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) upd_q <= '0;
      else        upd_q <= req;
   end

   genvar gc;
   generate
      for (gc = 0; gc < NUM_CH; gc++) begin : g_ch
         assign lsb_we[gc]   = wr_chan_hit && (wr_off[7:1] == 7'(gc)) && !wr_off[0];
         assign msb_we[gc]   = wr_chan_hit && (wr_off[7:1] == 7'(gc)) &&  wr_off[0];
         assign load_vec[gc] = upd_q[gc] | pin_fire;

         qdac_channel #(.CODE_W(CODE_W)) u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .lsb_we (lsb_we[gc]),
            .msb_we (msb_we[gc]),
            .wdata  (wr_data),
            .load   (load_vec[gc]),
            .staged (staged[gc]),
            .active (active[gc])
         );

         assign dac_code[gc*CODE_W +: CODE_W] = active[gc];
      end
   endgenerate

   // Read-back mux
   logic [CODE_W-1:0] rd_stage;
   always_comb begin
      rd_stage = staged[rd_off[2:1]];
      if (cfg_hit)          rd_data = cfg_rd_data;
      else if (rd_chan_hit) rd_data = rd_off[0] ? 8'(rd_stage[CODE_W-1:8]) : rd_stage[7:0];
      else                  rd_data = 8'h00;
   end

   AST_SW_MODE_PIN_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_mode && upd_q == '0) |=> $stable(dac_code)); // R5
   AST_WRITE_UPDATE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      (req != '0 && !pin_fire) |=> (upd_q == $past(req))); // R12
endmodule

// File: tb/qdac_load_ctrl_tb.sv
module qdac_load_ctrl_tb;
   localparam int CW = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [7:0]    wr_addr = '0;
   logic [7:0]    wr_data = '0;
   logic [7:0]    rd_addr = '0;
   logic [7:0]    rd_data;
   logic          load_n = 1'b1;
   logic [4*CW-1:0] dac_code;
   logic [3:0]    range_2x;
   logic          bypass_ab, bypass_cd, ref_internal, fast_conv;
   logic          therm_10bit, route_int_a, route_ext_b;

   int checks = 0;
   int failures = 0;
   int exp_act [4];
   int exp_stg [4];

   always #10 clk = ~clk;

   qdac_load_ctrl u_dut (
      .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_addr (wr_addr),
      .wr_data (wr_data), .rd_addr (rd_addr), .rd_data (rd_data),
      .load_n (load_n), .dac_code (dac_code), .range_2x (range_2x),
      .bypass_ab (bypass_ab), .bypass_cd (bypass_cd), .ref_internal (ref_internal),
      .fast_conv (fast_conv), .therm_10bit (therm_10bit),
      .route_int_a (route_int_a), .route_ext_b (route_ext_b)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd_chk(input string req, input logic [7:0] a, input int exp);
      rd_addr = a;
      #1;
      chk(req, $sformatf("read 0x%0h", a), int'(rd_data), exp);
   endtask

   task automatic act_chk(input string req);
      for (int i = 0; i < 4; i++)
         chk(req, $sformatf("active ch%0d", i), int'(dac_code[i*CW +: CW]), exp_act[i]);
   endtask

   task automatic stage(input int ch, input int v);
      wr(8'h10 + 8'(2*ch), 8'(v & 'hFF));
      wr(8'h11 + 8'(2*ch), 8'((v >> 8) & 'hF));
      exp_stg[ch] = v;
   endtask

   task automatic t_reset;
      rd_chk("R1", 8'h1A, 0);
      rd_chk("R1", 8'h1B, 0);
      rd_chk("R1", 8'h1C, 0);
      rd_chk("R1", 8'h17, 0);
      act_chk("R1");
      chk("R1", "selects", int'({range_2x, bypass_ab, bypass_cd, ref_internal,
          fast_conv, therm_10bit, route_int_a, route_ext_b}), 0);
   endtask

   task automatic t_cfg_bits;
      wr(8'h1A, 8'hF7);
      rd_chk("R2", 8'h1A, 'h63);
      chk("R2", "ctrl outputs", int'({fast_conv, therm_10bit, route_int_a, route_ext_b}), 'hF);
      wr(8'h1A, 8'h00);
      chk("R2", "ctrl outputs cleared", int'({fast_conv, therm_10bit, route_int_a, route_ext_b}), 0);
      wr(8'h1B, 8'hC5);
      rd_chk("R11", 8'h1B, 'hC5);
      chk("R11", "range", int'(range_2x), 'h5);
      chk("R11", "bypass", int'({bypass_ab, bypass_cd}), 'h3);
      wr(8'h1B, 8'h4A);
      chk("R11", "range2", int'(range_2x), 'hA);
      chk("R11", "bypass2", int'({bypass_ab, bypass_cd}), 'h2);
      wr(8'h1C, 8'hFF);  // pin mode: trigger bits have no effect
      rd_chk("R10", 8'h1C, 'h10);
      chk("R10", "ref_internal", int'(ref_internal), 1);
      @(negedge clk);
      act_chk("R4");
      wr(8'h1C, 8'h00);
      chk("R10", "ref external", int'(ref_internal), 0);
      wr(8'h1B, 8'h00);
   endtask

   task automatic pulse_pin(input string req, input bit expect_load);
      int pre [4];
      for (int i = 0; i < 4; i++) pre[i] = exp_act[i];
      @(negedge clk);
      load_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      act_chk(req);  // two edges in: not yet loaded
      @(negedge clk);
      if (expect_load) for (int i = 0; i < 4; i++) exp_act[i] = exp_stg[i];
      act_chk(req);
      load_n = 1'b1;
      repeat (4) @(negedge clk);
      act_chk(req);
   endtask

   task automatic t_pin_mode;
      wr(8'h10, 8'h34);
      rd_chk("R3", 8'h10, 0);  // low byte alone stages nothing
      wr(8'h11, 8'hFA);        // high nibble 0xA used
      exp_stg[0] = 'hA34;
      rd_chk("R3", 8'h10, 'h34);
      rd_chk("R3", 8'h11, 'h0A);
      stage(1, 'h5C1);
      stage(2, 'hFFF);
      stage(3, 'h801);
      @(negedge clk);
      act_chk("R4");           // high-byte writes do not load in pin mode
      pulse_pin("R4", 1'b1);
   endtask

   task automatic t_pin_ignored;
      wr(8'h1A, 8'h08);
      wr(8'h1B, 8'h30);
      stage(0, 'h111);
      stage(2, 'h222);
      pulse_pin("R5", 1'b0);
   endtask

   task automatic t_soft;
      // mode 11 still active from the previous scenario
      stage(1, 'h333);
      stage(3, 'h444);
      @(negedge clk);
      act_chk("R9");           // high-byte writes ignored in mode 11
      wr(8'h1C, 8'h02);
      @(negedge clk);
      exp_act[1] = exp_stg[1];
      act_chk("R9");
      rd_chk("R10", 8'h1C, 'h00);
      wr(8'h1C, 8'h0D);
      @(negedge clk);
      exp_act[0] = exp_stg[0]; exp_act[2] = exp_stg[2]; exp_act[3] = exp_stg[3];
      act_chk("R9");
   endtask

   task automatic t_single;
      wr(8'h1B, 8'h00);
      wr(8'h14, 8'h9D);
      wr(8'h15, 8'h07);
      exp_stg[2] = 'h79D;
      act_chk("R12");          // right after the write edge: not yet
      @(negedge clk);
      exp_act[2] = 'h79D;
      act_chk("R6");
      stage(0, 'hABC);
      @(negedge clk);
      exp_act[0] = 'hABC;
      act_chk("R6");
   endtask

   task automatic t_pair;
      wr(8'h1B, 8'h10);
      stage(0, 'h0F0);
      stage(2, 'h0E0);
      @(negedge clk);
      act_chk("R7");           // writes to A and C alone update nothing
      stage(1, 'h0D0);
      @(negedge clk);
      exp_act[0] = exp_stg[0]; exp_act[1] = exp_stg[1];
      act_chk("R7");
      stage(3, 'h0C0);
      @(negedge clk);
      exp_act[2] = exp_stg[2]; exp_act[3] = exp_stg[3];
      act_chk("R7");
   endtask

   task automatic t_all;
      wr(8'h1B, 8'h20);
      stage(0, 'h101);
      stage(1, 'h202);
      stage(2, 'h303);
      @(negedge clk);
      act_chk("R8");
      wr(8'h16, 8'h44);
      wr(8'h17, 8'h04);
      exp_stg[3] = 'h444;
      act_chk("R12");
      @(negedge clk);
      for (int i = 0; i < 4; i++) exp_act[i] = exp_stg[i];
      act_chk("R8");
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin : main
      for (int i = 0; i < 4; i++) begin exp_act[i] = 0; exp_stg[i] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_cfg_bits();
      t_pin_mode();
      t_pin_ignored();
      t_soft();
      t_single();
      t_pair();
      t_all();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule